// File: doc/BRIEF.md
# Phase-Sequenced Shared SRAM Bus Controller

This controller shares one address bus and one data bus between two static RAMs within each CPU cycle. One is a small, fast mapping RAM that holds page-translation entries. The other is a large main RAM. A fast clock runs at about eight times the pixel clock. Each fast-clock period is one tick of roughly 15 ns. While the CPU's phase-2 clock is high, the controller counts ticks and follows a fixed schedule:

- It first reads the translation entry for the current task and CPU page from the mapping RAM.
- It then spends one tick with every device disabled and the bus undriven.
- It then performs the real access. That access goes either to the mapping RAM, when software reads or writes a translation entry, or to the main RAM at the translated address.

The translation entry is captured at the end of the lookup. It is held for the rest of the cycle and forms the upper bits of the main-RAM address. An entry of zero means the page stays in internal memory, so the main RAM is left untouched.

Top module: `shared_bus_sequencer`

## Requirements
- R1: While phi2 is low, the tick counter `tick_o` is 0. All chip-enable, output-enable and write-enable outputs are high (inactive), `dq_oe` is 0 and `addr` is 0.
- R2: From the first fast-clock edge that samples phi2 high, `tick_o` takes the values 1, 2, 3, … on successive edges. It saturates at 2^CNT_W−1 (15 by default).
- R3: On ticks 2 and 3, only the mapping RAM is enabled, for reading (`map_ce_n`=0, `map_oe_n`=0). `addr` is {task_id, cpu_addr[15:12]}, zero-extended, and the data bus is not driven. On tick 1 no device is enabled.
- R4: On tick 4 every enable is inactive, `dq_oe` is 0 and `addr` is 0.
- R5: The low ENT_W bits of `dq_in` are captured at the fast-clock edge that ends tick 3. That value is held, whatever `dq_in` does afterwards, until the next lookup.
- R6: `req_kind` is encoded as 0 = data read, 1 = data write, 2 = mapping read and 3 = mapping write. On tick 5 and later, a mapping request enables the mapping RAM at `addr` = {task_id, cpu_addr[3:0]}. A mapping read also asserts `map_oe_n`. The main RAM stays disabled.
- R7: On tick 5 and later, a data request with a non-zero captured entry enables the main RAM at `addr` = {entry, cpu_addr[11:0]}. A data read also asserts `main_oe_n`. At most one chip enable is active at any time.
- R8: On tick 5 and later, a data request whose captured entry is zero asserts no main-RAM enable and drives nothing. `addr` is 0.
- R9: For write requests, the selected RAM's write enable is low only on tick 6 and later. `dq_oe` is 1 exactly while a write enable is low, and `dq_out` then equals `wr_data`.
- R10: When phi2 falls, every enable and `dq_oe` go inactive at once, without waiting for a fast-clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phi2 | input | 1 | CPU phase-2 clock |
| req_kind | input | 2 | Request type for this cycle (encoding in R6) |
| task_id | input | TASK_W | Current mapping set |
| cpu_addr | input | 16 | CPU address |
| wr_data | input | DW | CPU write data |
| dq_in | input | DW | Value read from the shared data bus |
| dq_out | output | DW | Value driven onto the shared data bus |
| dq_oe | output | 1 | Data bus drive enable |
| addr | output | ADDR_W | Shared address bus |
| map_ce_n | output | 1 | Mapping RAM chip enable, active low |
| map_oe_n | output | 1 | Mapping RAM output enable, active low |
| map_we_n | output | 1 | Mapping RAM write enable, active low |
| main_ce_n | output | 1 | Main RAM chip enable, active low |
| main_oe_n | output | 1 | Main RAM output enable, active low |
| main_we_n | output | 1 | Main RAM write enable, active low |
| tick_o | output | CNT_W | Current tick count |

## Verification
The hardest case to reach from the ports is a data access whose translated page is zero. To reach it, the lookup must return zero on the very tick the entry is captured, and the bus must then carry a different, non-zero value once the access phase begins. The bench models the mapping RAM as a function of the lookup address that yields zero for every fifth address. Whenever the mapping RAM is not being read, it feeds an unrelated value back on the data bus. A sweep over tasks, all sixteen CPU pages and all four request kinds therefore hits both zero and non-zero entries. The same sweep also shows that the captured entry survives the change on the bus.

// File: rtl/shared_bus_sequencer.sv
module shared_bus_sequencer #(
  parameter int TASK_W = 8,
  parameter int ENT_W  = 7,
  parameter int CNT_W  = 4,
  parameter int DW     = 8,
  localparam int MAP_AW  = TASK_W + 4,
  localparam int MAIN_AW = ENT_W + 12,
  localparam int ADDR_W  = (MAIN_AW > MAP_AW) ? MAIN_AW : MAP_AW
) (
  input  logic              clk_fast,
  input  logic              rst_n,
  input  logic              phi2,
  input  logic [1:0]        req_kind,
  input  logic [TASK_W-1:0] task_id,
  input  logic [15:0]       cpu_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [DW-1:0]     dq_in,
  output logic [DW-1:0]     dq_out,
  output logic              dq_oe,
  output logic [ADDR_W-1:0] addr,
  output logic              map_ce_n,
  output logic              map_oe_n,
  output logic              map_we_n,
  output logic              main_ce_n,
  output logic              main_oe_n,
  output logic              main_we_n,
  output logic [CNT_W-1:0]  tick_o
);

  localparam logic [CNT_W-1:0] T_MAX   = '1;
  localparam logic [CNT_W-1:0] T_LOOK0 = CNT_W'(2);
  localparam logic [CNT_W-1:0] T_LOOK1 = CNT_W'(3);
  localparam logic [CNT_W-1:0] T_ACC   = CNT_W'(5);
  localparam logic [CNT_W-1:0] T_WR    = CNT_W'(6);

  logic [CNT_W-1:0] tick;
  logic [ENT_W-1:0] entry;

  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n)           tick <= '0;
    else if (!phi2)       tick <= '0;
    else if (tick != T_MAX) tick <= tick + 1'b1;
  end

  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n)                      entry <= '0;
    else if (phi2 && tick == T_LOOK1) entry <= dq_in[ENT_W-1:0];
  end

  wire is_map   = req_kind[1];
  wire is_wr    = req_kind[0];
  wire lookup   = phi2 && (tick == T_LOOK0 || tick == T_LOOK1);
  wire access   = phi2 && (tick >= T_ACC);
  wire late     = phi2 && (tick >= T_WR);
  wire map_acc  = access && is_map;
  wire main_acc = access && !is_map && (entry != '0);

  assign map_ce_n  = !(lookup || map_acc);
  assign map_oe_n  = !(lookup || (map_acc && !is_wr));
  assign map_we_n  = !(late && is_map && is_wr);
  assign main_ce_n = !main_acc;
  assign main_oe_n = !(main_acc && !is_wr);
  assign main_we_n = !(late && main_acc && is_wr);
  assign dq_oe     = !map_we_n || !main_we_n;
  assign dq_out    = wr_data;
  assign tick_o    = tick;

  always_comb begin
    if (lookup)        addr = ADDR_W'({task_id, cpu_addr[15:12]});
    else if (map_acc)  addr = ADDR_W'({task_id, cpu_addr[3:0]});
    else if (main_acc) addr = ADDR_W'({entry, cpu_addr[11:0]});
    else               addr = '0;
  end

endmodule

// File: rtl/shared_bus_sequencer_chk.sv
module shared_bus_sequencer_chk #(
  parameter int CNT_W = 4,
  parameter int ENT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             phi2,
  input logic [CNT_W-1:0] tick,
  input logic [ENT_W-1:0] entry,
  input logic             map_ce_n,
  input logic             map_oe_n,
  input logic             map_we_n,
  input logic             main_ce_n,
  input logic             main_oe_n,
  input logic             main_we_n,
  input logic             dq_oe
);

  localparam logic [CNT_W-1:0] C_MAX  = '1;
  localparam logic [CNT_W-1:0] C_THREE = CNT_W'(3);
  localparam logic [CNT_W-1:0] C_FOUR  = CNT_W'(4);
  localparam logic [CNT_W-1:0] C_SIX   = CNT_W'(6);

  AST_IDLE_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(phi2) |-> tick == '0); // R1

  AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phi2) && $past(tick) != C_MAX) |-> tick == $past(tick) + 1'b1); // R2

  AST_TICK_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phi2) && $past(tick) == C_MAX) |-> tick == C_MAX); // R2

  AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
    (phi2 && tick == C_FOUR) |-> (map_ce_n && map_oe_n && map_we_n && main_ce_n && main_oe_n && main_we_n && !dq_oe)); // R4

  AST_ENTRY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !($past(phi2) && $past(tick) == C_THREE) |-> $stable(entry)); // R5

  AST_ONE_DEVICE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~map_ce_n, ~main_ce_n}) <= 1); // R7

  AST_WE_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!map_we_n || !main_we_n) |-> (phi2 && tick >= C_SIX)); // R9

  AST_DRIVE_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (!map_we_n || !main_we_n)); // R9

  AST_LOW_PHI2_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !phi2 |-> (map_ce_n && main_ce_n && map_we_n && main_we_n && !dq_oe)); // R10

endmodule

bind shared_bus_sequencer shared_bus_sequencer_chk #(.CNT_W(CNT_W), .ENT_W(ENT_W)) u_chk (
  .clk(clk_fast), .rst_n(rst_n), .phi2(phi2), .tick(tick), .entry(entry),
  .map_ce_n(map_ce_n), .map_oe_n(map_oe_n), .map_we_n(map_we_n),
  .main_ce_n(main_ce_n), .main_oe_n(main_oe_n), .main_we_n(main_we_n), .dq_oe(dq_oe)
);

// File: tb/shared_bus_sequencer_tb.sv
`timescale 1ns/1ps
module shared_bus_sequencer_tb;
  localparam int TASK_W = 8, ENT_W = 7, CNT_W = 4, DW = 8, ADDR_W = 19;

  logic clk = 0, rst_n = 0, phi2 = 0;
  logic [1:0] req_kind = 0;
  logic [TASK_W-1:0] task_id = 0;
  logic [15:0] cpu_addr = 0;
  logic [DW-1:0] wr_data = 0;
  logic [DW-1:0] dq_in, dq_out;
  logic dq_oe, map_ce_n, map_oe_n, map_we_n, main_ce_n, main_oe_n, main_we_n;
  logic [ADDR_W-1:0] addr;
  logic [CNT_W-1:0] tick_o;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  shared_bus_sequencer u_dut (
    .clk_fast(clk), .rst_n(rst_n), .phi2(phi2), .req_kind(req_kind), .task_id(task_id),
    .cpu_addr(cpu_addr), .wr_data(wr_data), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
    .addr(addr), .map_ce_n(map_ce_n), .map_oe_n(map_oe_n), .map_we_n(map_we_n),
    .main_ce_n(main_ce_n), .main_oe_n(main_oe_n), .main_we_n(main_we_n), .tick_o(tick_o));

  function automatic logic [DW-1:0] map_model(input logic [11:0] a);
    logic [6:0] v;
    v = 7'((a * 13 + (a >> 5) + 1) & 12'h7F);
    if (a % 5 == 0) v = '0;
    return {a[0], v};
  endfunction

  always_comb dq_in = !map_oe_n ? map_model(addr[11:0]) : (8'hC3 ^ addr[7:0]);

  task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_idle(input string req);
    cmp(req, {map_ce_n, map_oe_n, map_we_n, main_ce_n, main_oe_n, main_we_n, dq_oe}, 7'b1111110);
    cmp(req, addr, 0);
  endtask

  task automatic check_tick(input int k, input logic [6:0] ent);
    logic [6:0] ctl;
    logic [ADDR_W-1:0] ea;
    string tag;
    int kk;
    kk = (k > 15) ? 15 : k;
    ctl = 7'b1111110; ea = '0;
    if (kk <= 1) tag = "R2";
    else if (kk <= 3) begin
      tag = "R3"; ctl = 7'b0011110; ea = ADDR_W'({task_id, cpu_addr[15:12]});
    end else if (kk == 4) tag = "R4";
    else if (req_kind[1]) begin
      tag = "R6"; ctl[6] = 0; ea = ADDR_W'({task_id, cpu_addr[3:0]});
      if (!req_kind[0]) ctl[5] = 0;
      else if (kk >= 6) begin ctl[4] = 0; ctl[0] = 1; tag = "R9"; end
    end else if (ent == 0) tag = "R8";
    else begin
      tag = "R7"; ctl[3] = 0; ea = ADDR_W'({ent, cpu_addr[11:0]});
      if (!req_kind[0]) ctl[2] = 0;
      else if (kk >= 6) begin ctl[1] = 0; ctl[0] = 1; tag = "R9"; end
    end
    cmp("R2", tick_o, kk);
    cmp(tag, {map_ce_n, map_oe_n, map_we_n, main_ce_n, main_oe_n, main_we_n, dq_oe}, ctl);
    cmp((kk >= 5) ? "R5" : tag, addr, ea);
    if (ctl[0]) cmp("R9", dq_out, wr_data);
  endtask

  task automatic run_cycle(input logic [7:0] t, input logic [15:0] a, input logic [1:0] kind, input int hi);
    logic [6:0] ent;
    @(negedge clk);
    task_id = t; cpu_addr = a; req_kind = kind; wr_data = t ^ a[15:8] ^ 8'h5A; phi2 = 1;
    ent = map_model({t, a[15:12]})[6:0];
    for (int k = 1; k <= hi; k++) begin
      @(posedge clk); #1;
      check_tick(k, ent);
    end
    @(negedge clk); phi2 = 0; #1;
    check_idle("R10");
    @(posedge clk); #1;
    cmp("R1", tick_o, 0);
    check_idle("R1");
  endtask

  initial begin
    #5000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    cmp("R1", tick_o, 0);
    check_idle("R1");
    @(negedge clk); rst_n = 1;
    repeat (2) @(posedge clk); #1;
    cmp("R1", tick_o, 0);
    check_idle("R1");
    foreach (task_id[i]) ;
    for (int ti = 0; ti < 4; ti++) begin
      logic [7:0] tv;
      tv = (ti == 0) ? 8'h00 : (ti == 1) ? 8'h01 : (ti == 2) ? 8'hA5 : 8'hFF;
      for (int pg = 0; pg < 16; pg++)
        for (int kd = 0; kd < 4; kd++)
          run_cycle(tv, {4'(pg), 12'(pg * 12'h111 ^ tv)}, 2'(kd), 10);
    end
    run_cycle(8'h3C, 16'h7ABC, 2'd1, 20);
    run_cycle(8'h3C, 16'h7ABC, 2'd3, 20);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule